// File: doc/BRIEF.md
# Memory Region Access Checker with Violation Capture

The block holds a set of memory-region descriptors and rules on every bus access that passes by. Each descriptor has a start and an end address, kept only down to a fixed granule, and a 2-bit permission code for each domain. It also has an enable bit and a lock bit. An access supplies its address, the domain that issued it and whether it is a write. The checker finds every enabled region that contains the address. The access is granted only when each of those regions allows the operation to that domain.

Each region keeps a record of the first access it refused: the domain and the granule address of the offending access, plus a flag. A simple register port lets software program the descriptors and read the records. A status read clears the record only when the reading domain holds a permission other than none in that region. Writing the flag bit clears the record from any domain. A region lock freezes the addresses and the policy until reset. While locked, the region can still be switched on but can no longer be switched off.

Top module: `mrg_region_guard`

## Requirements
- R1: The policy field holds the code for domain d at bits [2d+1:2d]. Code 0 allows nothing, 1 allows writes only, 2 allows reads only and 3 allows both. A matching region refuses any operation that its code does not allow.
- R2: A region matches when it is enabled and base <= address < end, compared at granule resolution. A disabled region never refuses an access, and an address equal to end does not match.
- R3: When several regions match, the access is granted only if every one of them allows it.
- R4: The base and end registers drop the address bits below the granule (RES_BITS, default 12). Those bits read back as zero.
- R5: Once the lock bit (control bit 2*NUM_DOMAINS+1, bit 9 by default) is set, base, end, policy and the lock itself ignore writes until reset.
- R6: In a locked region, a control write with the enable bit (control bit 2*NUM_DOMAINS, bit 8 by default) set turns the region on. A control write with that bit clear never turns it off.
- R7: A refused access records the violation in that region's status register: bit 0 is the flag, bits [DOM_W:1] hold the domain and bits [ADDR_W-1:RES_BITS] hold the granule address.
- R8: While the flag is set, later violations leave the record unchanged.
- R9: A status read clears the record after that cycle only if the reader's domain (cfg_dom) has a code other than 0 in that region. Reads from other domains leave it intact.
- R10: A status write with bit 0 set clears the record.
- R11: After reset every region reads base 0, end 0, control 0xFF (read and write for all four domains, disabled, unlocked) and status 0.
- R12: acc_grant and acc_deny are never high together, both stay low without acc_valid, and acc_deny is high exactly when a valid access is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (drives read-clear of status) |
| cfg_idx | input | IDX_W | Region index |
| cfg_sel | input | 2 | Register select: 0 base, 1 end, 2 control, 3 status |
| cfg_wdata | input | ADDR_W | Write data |
| cfg_dom | input | DOM_W | Domain of the register access |
| cfg_rdata | output | ADDR_W | Read data, combinational from idx and sel |
| acc_valid | input | 1 | An access is being checked |
| acc_addr | input | ADDR_W | Access address |
| acc_dom | input | DOM_W | Domain issuing the access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_grant | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused |

## Verification
The bound checker watches on every cycle that grant and deny stay exclusive and quiet when idle, and that a lock, once set, holds. It also checks that a locked region keeps its addresses and policy and never drops its enable, that a held record stays frozen until a clear, and that a clear or a fresh violation acts on the flag in the next cycle. The bench scenarios show the rest: the permission decode per domain and per operation, the exclusive end bound, the combination of overlapping regions and the exact field layout of a captured record. They also cover which domains are allowed to clear a record by reading it, the granule truncation and the reset contents.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
   localparam logic [1:0] SEL_BASE = 2'd0;
   localparam logic [1:0] SEL_END  = 2'd1;
   localparam logic [1:0] SEL_CTRL = 2'd2;
   localparam logic [1:0] SEL_STAT = 2'd3;

   // Decide whether a 2-bit permission code allows the operation
   function automatic logic code_permits(input logic [1:0] code, input logic is_write);
      return is_write ? code[0] : code[1];
   endfunction
endpackage

// File: rtl/mrg_desc.sv
module mrg_desc
   import mrg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int RES_BITS    = 12,
   parameter int NUM_DOMAINS = 4,
   parameter int DOM_W       = 2,
   localparam int GW = ADDR_W - RES_BITS,
   localparam int PW = 2 * NUM_DOMAINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DOM_W-1:0]  acc_dom,
   input  logic              acc_write,
   output logic [GW-1:0]     base_g,
   output logic [GW-1:0]     end_g,
   output logic [PW-1:0]     policy,
   output logic              en,
   output logic              lk,
   output logic              deny
);
   logic [GW-1:0] acc_g;
   logic [1:0]    code;
   logic          hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_g <= '0;
         end_g  <= '0;
         policy <= '1;
         en     <= 1'b0;
         lk     <= 1'b0;
      end else if (wr_en) begin
         if (wr_sel == SEL_BASE && !lk) base_g <= wr_data[ADDR_W-1:RES_BITS];
         if (wr_sel == SEL_END && !lk)  end_g  <= wr_data[ADDR_W-1:RES_BITS];
         if (wr_sel == SEL_CTRL) begin
            if (!lk) begin
               policy <= wr_data[PW-1:0];
               en     <= wr_data[PW];
               lk     <= wr_data[PW+1];
            end else if (wr_data[PW]) begin
               en <= 1'b1;
            end
         end
      end
   end

   assign acc_g = acc_addr[ADDR_W-1:RES_BITS];
   assign hit   = en && (acc_g >= base_g) && (acc_g < end_g);

   always_comb begin
      code = 2'b00;
      for (int d = 0; d < NUM_DOMAINS; d++)
         if (acc_dom == DOM_W'(d)) code = policy[2*d +: 2];
   end

   assign deny = acc_valid && hit && !code_permits(code, acc_write);
endmodule

// File: rtl/mrg_vrec.sv
module mrg_vrec #(
   parameter int GW    = 20,
   parameter int DOM_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             viol,
   input  logic [DOM_W-1:0] viol_dom,
   input  logic [GW-1:0]    viol_g,
   input  logic             clr,
   output logic             flag,
   output logic [DOM_W-1:0] rec_dom,
   output logic [GW-1:0]    rec_g
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         rec_dom <= '0;
         rec_g   <= '0;
      end else if (clr || !flag) begin
         if (viol) begin
            flag    <= 1'b1;
            rec_dom <= viol_dom;
            rec_g   <= viol_g;
         end else if (clr) begin
            flag    <= 1'b0;
            rec_dom <= '0;
            rec_g   <= '0;
         end
      end
   end
endmodule

// File: rtl/mrg_region_guard.sv
module mrg_region_guard
   import mrg_pkg::*;
#(
   parameter int NUM_REGIONS = 4,
   parameter int NUM_DOMAINS = 4,
   parameter int ADDR_W      = 32,
   parameter int RES_BITS    = 12,
   localparam int DOM_W = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1,
   localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_re,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [DOM_W-1:0]  cfg_dom,
   output logic [ADDR_W-1:0] cfg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DOM_W-1:0]  acc_dom,
   input  logic              acc_write,
   output logic              acc_grant,
   output logic              acc_deny
);
   localparam int GW = ADDR_W - RES_BITS;
   localparam int PW = 2 * NUM_DOMAINS;

   if (RES_BITS < DOM_W + 1) begin : g_bad_res
      $error("RES_BITS too small to hold the status flag and domain");
   end
   if (ADDR_W < PW + 2 || RES_BITS >= ADDR_W) begin : g_bad_width
      $error("ADDR_W too small for control or granule layout");
   end
   if (NUM_REGIONS < 1 || NUM_DOMAINS < 2) begin : g_bad_count
      $error("need at least one region and two domains");
   end

   logic [NUM_REGIONS-1:0][GW-1:0]    base_a, end_a, vaddr_a;
   logic [NUM_REGIONS-1:0][PW-1:0]    pol_a;
   logic [NUM_REGIONS-1:0][DOM_W-1:0] vdom_a;
   logic [NUM_REGIONS-1:0]            en_a, lk_a, deny_a, clr_a, flag_a;

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
      logic       sel_me;
      logic [1:0] rd_code;

      assign sel_me = (cfg_idx == IDX_W'(i));

      mrg_desc #(
         .ADDR_W(ADDR_W), .RES_BITS(RES_BITS),
         .NUM_DOMAINS(NUM_DOMAINS), .DOM_W(DOM_W)
      ) u_desc (
         .clk(clk), .rst_n(rst_n),
         .wr_en(cfg_we && sel_me), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
         .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_dom(acc_dom),
         .acc_write(acc_write),
         .base_g(base_a[i]), .end_g(end_a[i]), .policy(pol_a[i]),
         .en(en_a[i]), .lk(lk_a[i]), .deny(deny_a[i])
      );

      always_comb begin
         rd_code = 2'b00;
         for (int d = 0; d < NUM_DOMAINS; d++)
            if (cfg_dom == DOM_W'(d)) rd_code = pol_a[i][2*d +: 2];
      end

      assign clr_a[i] = sel_me && (cfg_sel == SEL_STAT) &&
                        ((cfg_re && rd_code != 2'b00) || (cfg_we && cfg_wdata[0]));

      mrg_vrec #(.GW(GW), .DOM_W(DOM_W)) u_vrec (
         .clk(clk), .rst_n(rst_n),
         .viol(deny_a[i]), .viol_dom(acc_dom), .viol_g(acc_addr[ADDR_W-1:RES_BITS]),
         .clr(clr_a[i]),
         .flag(flag_a[i]), .rec_dom(vdom_a[i]), .rec_g(vaddr_a[i])
      );
   end

   assign acc_deny  = |deny_a;
   assign acc_grant = acc_valid && !acc_deny;

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (cfg_idx == IDX_W'(i)) begin
            case (cfg_sel)
               SEL_BASE: cfg_rdata = {base_a[i], {RES_BITS{1'b0}}};
               SEL_END:  cfg_rdata = {end_a[i], {RES_BITS{1'b0}}};
               SEL_CTRL: cfg_rdata = ADDR_W'({lk_a[i], en_a[i], pol_a[i]});
               default:  cfg_rdata = {vaddr_a[i], {(RES_BITS-DOM_W-1){1'b0}}, vdom_a[i], flag_a[i]};
            endcase
         end
      end
   end
endmodule

// File: rtl/mrg_guard_chk.sv
module mrg_guard_chk #(
   parameter int NR    = 4,
   parameter int GW    = 20,
   parameter int PW    = 8,
   parameter int DOM_W = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      acc_valid,
   input logic                      acc_grant,
   input logic                      acc_deny,
   input logic [NR-1:0][GW-1:0]     base_a,
   input logic [NR-1:0][GW-1:0]     end_a,
   input logic [NR-1:0][GW-1:0]     vaddr_a,
   input logic [NR-1:0][PW-1:0]     pol_a,
   input logic [NR-1:0][DOM_W-1:0]  vdom_a,
   input logic [NR-1:0]             en_a,
   input logic [NR-1:0]             lk_a,
   input logic [NR-1:0]             deny_a,
   input logic [NR-1:0]             clr_a,
   input logic [NR-1:0]             flag_a
);
   AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_grant && acc_deny)); // R12
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!acc_grant && !acc_deny)); // R12

   for (genvar i = 0; i < NR; i++) begin : g_chk
      AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         lk_a[i] |=> lk_a[i]); // R5
      AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         lk_a[i] |=> ($stable(base_a[i]) && $stable(end_a[i]) && $stable(pol_a[i]))); // R5
      AST_LOCKED_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (lk_a[i] && en_a[i]) |=> en_a[i]); // R6
      AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_a[i] && !clr_a[i]) |=> (flag_a[i] && $stable(vdom_a[i]) && $stable(vaddr_a[i]))); // R8
      AST_CAPTURE_SET: assert property (@(posedge clk) disable iff (!rst_n)
         deny_a[i] |=> flag_a[i]); // R7
      AST_CLEAR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_a[i] && !deny_a[i]) |=> !flag_a[i]); // R10
   end
endmodule

bind mrg_region_guard mrg_guard_chk #(
   .NR(NUM_REGIONS), .GW(ADDR_W - RES_BITS), .PW(2 * NUM_DOMAINS), .DOM_W(DOM_W)
) u_chk (.*);

// File: tb/mrg_region_guard_test.sv
module mrg_region_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_re = 1'b0;
   logic [1:0]  cfg_idx = '0, cfg_sel = '0, cfg_dom = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_dom = '0;
   logic        acc_grant, acc_deny;
   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mrg_region_guard uut (.*);

   // {addr, domain, write, expected grant}
   localparam logic [35:0] VEC [12] = '{
      {32'h0000_0800, 2'd0, 1'b0, 1'b1},  // R2 outside all regions
      {32'h0000_1000, 2'd0, 1'b1, 1'b1},  // R1 dom0 RW write
      {32'h0000_1FFF, 2'd1, 1'b0, 1'b1},  // R1 dom1 RO read
      {32'h0000_1FFF, 2'd1, 1'b1, 1'b0},  // R1 dom1 RO write refused
      {32'h0000_1800, 2'd2, 1'b1, 1'b1},  // R1 dom2 WO write
      {32'h0000_1800, 2'd2, 1'b0, 1'b0},  // R1 dom2 WO read refused
      {32'h0000_1000, 2'd3, 1'b0, 1'b0},  // R1 dom3 none
      {32'h0000_2800, 2'd0, 1'b0, 1'b0},  // R3 r1 refuses dom0
      {32'h0000_2800, 2'd1, 1'b0, 1'b1},  // R3 both allow
      {32'h0000_3000, 2'd3, 1'b1, 1'b1},  // R2 end of r0 exclusive
      {32'h0000_4000, 2'd0, 1'b1, 1'b1},  // R2 end of r1 exclusive
      {32'h0000_2FFF, 2'd1, 1'b1, 1'b0}   // R3 r0 refuses
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] idx, input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_idx = idx; cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [1:0] idx, input logic [1:0] sel,
                     input logic [1:0] dom, input logic [31:0] exp);
      @(negedge clk);
      cfg_idx = idx; cfg_sel = sel; cfg_dom = dom; cfg_re = 1'b1;
      #1 chk(tag, cfg_rdata, exp);
      @(negedge clk);
      cfg_re = 1'b0;
   endtask

   task automatic acc(input string tag, input logic [31:0] a, input logic [1:0] d,
                      input logic w, input logic exp);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_dom = d; acc_write = w;
      #1 chk(tag, {30'd0, acc_grant, acc_deny}, {30'd0, exp, !exp});
      @(negedge clk);
      acc_valid = 1'b0;
      #1 chk({tag, " idle"}, {30'd0, acc_grant, acc_deny}, 32'd0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset contents
      rd("R11 base", 2'd3, 2'd0, 2'd0, 32'h0);
      rd("R11 end",  2'd3, 2'd1, 2'd0, 32'h0);
      rd("R11 ctrl", 2'd3, 2'd2, 2'd0, 32'h0000_00FF);
      rd("R11 stat", 2'd3, 2'd3, 2'd0, 32'h0);
      acc("R11 no region enabled", 32'h0, 2'd3, 1'b0, 1'b1);

      // r0: 0x1000..0x3000, dom0 RW, dom1 RO, dom2 WO, dom3 none
      wr(2'd0, 2'd0, 32'h0000_1000);
      wr(2'd0, 2'd1, 32'h0000_3000);
      wr(2'd0, 2'd2, 32'h0000_011B);
      // r1: 0x2000..0x4000, dom0 none, others RW
      wr(2'd1, 2'd0, 32'h0000_2000);
      wr(2'd1, 2'd1, 32'h0000_4000);
      wr(2'd1, 2'd2, 32'h0000_01FC);

      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         acc_valid = 1'b1; acc_addr = VEC[k][35:4]; acc_dom = VEC[k][3:2];
         acc_write = VEC[k][1];
         #1 chk($sformatf("R1/R2/R3 vector %0d", k), {30'd0, acc_grant, acc_deny},
                {30'd0, VEC[k][0], !VEC[k][0]});
      end
      @(negedge clk);
      acc_valid = 1'b0;

      // R7 R8 first refusal kept per region
      rd("R7 r0 record by dom3 (R9 no clear)", 2'd0, 2'd3, 2'd3, 32'h0000_1003);
      rd("R9 r0 record kept", 2'd0, 2'd3, 2'd3, 32'h0000_1003);
      rd("R9 r0 read by owner", 2'd0, 2'd3, 2'd1, 32'h0000_1003);
      rd("R9 r0 cleared", 2'd0, 2'd3, 2'd1, 32'h0);
      rd("R8 r1 first record", 2'd1, 2'd3, 2'd0, 32'h0000_2001);
      rd("R9 r1 read by dom0 no clear", 2'd1, 2'd3, 2'd0, 32'h0000_2001);
      wr(2'd1, 2'd3, 32'h0000_0001);
      rd("R10 r1 cleared by write", 2'd1, 2'd3, 2'd0, 32'h0);

      acc("R1 dom3 read refused", 32'h0000_1000, 2'd3, 1'b0, 1'b0);
      acc("R1 dom2 read refused", 32'h0000_1004, 2'd2, 1'b0, 1'b0);
      rd("R8 only first kept", 2'd0, 2'd3, 2'd3, 32'h0000_1007);
      wr(2'd0, 2'd3, 32'h0000_0001);
      rd("R10 r0 cleared by write", 2'd0, 2'd3, 2'd3, 32'h0);

      // R4 granule truncation, R2 disabled region
      wr(2'd3, 2'd0, 32'h0000_8ABC);
      rd("R4 base truncated", 2'd3, 2'd0, 2'd0, 32'h0000_8000);
      wr(2'd3, 2'd1, 32'h0000_9FFF);
      rd("R4 end truncated", 2'd3, 2'd1, 2'd0, 32'h0000_9000);
      wr(2'd3, 2'd2, 32'h0000_0000);
      acc("R2 disabled region no check", 32'h0000_8000, 2'd0, 1'b0, 1'b1);
      wr(2'd3, 2'd2, 32'h0000_0100);
      acc("R2 enabled region checks", 32'h0000_8FFF, 2'd0, 1'b0, 1'b0);
      acc("R2 end exclusive", 32'h0000_9000, 2'd0, 1'b0, 1'b1);

      // R5 R6 lock
      wr(2'd0, 2'd2, 32'h0000_031B);
      rd("R5 ctrl locked", 2'd0, 2'd2, 2'd0, 32'h0000_031B);
      wr(2'd0, 2'd2, 32'h0000_00FF);
      rd("R6 enable not cleared, policy held", 2'd0, 2'd2, 2'd0, 32'h0000_031B);
      wr(2'd0, 2'd0, 32'h0000_5000);
      rd("R5 base frozen", 2'd0, 2'd0, 2'd0, 32'h0000_1000);
      wr(2'd0, 2'd1, 32'h0000_7000);
      rd("R5 end frozen", 2'd0, 2'd1, 2'd0, 32'h0000_3000);
      wr(2'd2, 2'd2, 32'h0000_02FF);
      wr(2'd2, 2'd2, 32'h0000_0100);
      rd("R6 locked region enabled", 2'd2, 2'd2, 2'd0, 32'h0000_03FF);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule